// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is a single programmable logic cell. It takes a literal bus and offers each literal in true and complement form to sixteen AND terms. Each AND term has its own static inclusion masks. Eight of the terms form the logic function, as two groups of four. The other eight are paired to produce four control signals: output enable, asynchronous preset, asynchronous clear and a locally generated clock.

The logic sum passes through a polarity XOR and then into one storage bit. Static mode bits make that bit behave as a D, T, JK or SR flip-flop, or bypass it so the output is purely combinational. The bit is clocked either by the global clock or by the product-term clock. The cell value drives a pad output whose enable comes from the product-term output enable. The cell returns two feedbacks:
- an internal one, which always carries the cell value;
- a pin one, which reads the pad. With the output enable low, the pin feedback carries the external pad value, so a buried register and a pin input can coexist.

Top module: `sop_macrocell`

## Requirements
- R1: The array literal vector has `clk_i` at index 0 and `lit_i[i]` at index i+1. For term k, fuse bit `fuse_i[k*2L+i]` includes literal i in true form, and `fuse_i[k*2L+L+i]` includes it in complement form (L = N_LIT+1). A term is the AND of its included literals. With every bit included a term is 0, and with none included it is 1.
- R2: Terms 0-3 form group A and terms 4-7 form group B. The cell value in bypass mode (`mode_i` = 4, and also 5-7) is (A OR B) XOR `inv_i`, with no clock involved.
- R3: In D mode (`mode_i` = 0), the storage bit takes (A OR B) XOR `inv_i` on each selected clock rising edge.
- R4: In T mode (`mode_i` = 1), the storage bit inverts on a selected clock edge when (A OR B) XOR `inv_i` is 1, and holds otherwise.
- R5: In JK mode (`mode_i` = 2), A is J and B is K. The bit holds for 00, sets for 10, clears for 01 and toggles for 11.
- R6: In SR mode (`mode_i` = 3), A is S and B is R. The bit sets for S only, clears for R only, and holds when both or neither are active.
- R7: The OR of terms 12-13 clears the bit at once, without a clock. The OR of terms 10-11 presets it at once. When both are active, clear wins.
- R8: With `clk_async_i` = 0 the bit is clocked by `clk_i` rising. With `clk_async_i` = 1 it is clocked only by the rising edge of the OR of terms 14-15.
- R9: While `clk_async_i` = 0, literal 0 (the global clock) is dropped from every term, as if neither of its fuse bits were included.
- R10: `pad_oe_o` is the OR of terms 8-9. When it is 1, `pin_fb_o` equals `pad_o`. When it is 0, `pin_fb_o` equals `pad_i`.
- R11: `pad_o` and `int_fb_o` carry the cell value whatever the output enable is. In register modes that value is the storage bit.
- R12: While `rst_ni` is low, the storage bit is 0, both in the initial power-up state and when reset is asserted mid-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock, also literal 0 of the array |
| rst_ni | input | 1 | Active-low asynchronous reset of the storage bit |
| lit_i | input | N_LIT | Literal bus from the global interconnect |
| fuse_i | input | 16*2*(N_LIT+1) | Static AND-array inclusion masks, true then complement per term |
| mode_i | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4-7 bypass |
| inv_i | input | 1 | Output polarity XOR control |
| clk_async_i | input | 1 | 1 selects the product-term clock |
| pad_i | input | 1 | Value seen on the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad driver enable, 0 means high impedance |
| int_fb_o | output | 1 | Internal feedback of the cell value |
| pin_fb_o | output | 1 | Feedback taken from the pad |

## Verification
A wrong storage bit appears on `int_fb_o` right after the offending clock edge, and on `pad_o` whenever the enable is high. The mode tests therefore compare every edge of a short sequence, in which each step's expected value depends on the previous one. The bench checks asynchronous preset, clear and the product-term clock about a nanosecond after the literal change, because they must act without a global edge. A stray edge on the wrong clock source shows up as a change at a global edge that should have been a hold. Literal masking shows up as a combinational output that differs between the two clock phases.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    MC_D   = 3'd0,
    MC_T   = 3'd1,
    MC_JK  = 3'd2,
    MC_SR  = 3'd3,
    MC_BYP = 3'd4
  } mc_mode_e;

  localparam int CTL_OE  = 0;
  localparam int CTL_PRE = 1;
  localparam int CTL_CLR = 2;
  localparam int CTL_CLK = 3;
  localparam int N_CTL   = 4;

  function automatic logic mode_is_reg(logic [2:0] m);
    return m < 3'(MC_BYP);
  endfunction
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int W = 9
) (
  input  logic [W-1:0] lit_i,
  input  logic [W-1:0] use_t_i,
  input  logic [W-1:0] use_c_i,
  input  logic [W-1:0] drop_i,
  output logic         term_o
);
  logic [W-1:0] pass;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      pass[i] = drop_i[i] | ((~use_t_i[i] | lit_i[i]) & (~use_c_i[i] | ~lit_i[i]));
    end
  end

  assign term_o = &pass;
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       clr_i,
  input  logic       pre_i,
  input  logic [2:0] mode_i,
  input  logic       d_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       q_o
);
  logic nxt;

  always_comb begin
    nxt = q_o;
    case (mode_i)
      MC_D:  nxt = d_i;
      MC_T:  nxt = q_o ^ d_i;
      MC_JK: begin
        case ({a_i, b_i})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~q_o;
          default: nxt = q_o;
        endcase
      end
      MC_SR: begin
        case ({a_i, b_i})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = q_o;  // 11 holds
        endcase
      end
      default: nxt = q_o;
    endcase
  end

  // clear outranks preset
  always_ff @(posedge clk_i or posedge clr_i or posedge pre_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (pre_i) q_o <= 1'b1;
    else            q_o <= nxt;
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import mc_pkg::*;
#(
  parameter  int N_LIT      = 8,
  parameter  int GRP_TERMS  = 4,
  parameter  int CTRL_TERMS = 2,
  localparam int N_ARR      = N_LIT + 1,
  localparam int FUSE_W     = 2 * N_ARR,
  localparam int LOG_TERMS  = 2 * GRP_TERMS,
  localparam int N_TERM     = LOG_TERMS + N_CTL * CTRL_TERMS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LIT-1:0]         lit_i,
  input  logic [N_TERM*FUSE_W-1:0] fuse_i,
  input  logic [2:0]               mode_i,
  input  logic                     inv_i,
  input  logic                     clk_async_i,
  input  logic                     pad_i,
  output logic                     pad_o,
  output logic                     pad_oe_o,
  output logic                     int_fb_o,
  output logic                     pin_fb_o
);
  logic [N_ARR-1:0]  arr;
  logic [N_ARR-1:0]  drop;
  logic [N_TERM-1:0] pt;
  logic [N_CTL-1:0]  ctl;
  logic grp_a, grp_b, d_val, reg_clk, clr_a, pre_a, q, val;

  assign arr  = {lit_i, clk_i};
  // global clock cannot be a literal while it clocks the register
  assign drop = {{N_LIT{1'b0}}, ~clk_async_i};

  for (genvar k = 0; k < N_TERM; k++) begin : g_pt
    mc_pterm #(.W(N_ARR)) u_pt (
      .lit_i  (arr),
      .use_t_i(fuse_i[k*FUSE_W +: N_ARR]),
      .use_c_i(fuse_i[k*FUSE_W+N_ARR +: N_ARR]),
      .drop_i (drop),
      .term_o (pt[k])
    );
  end

  for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
    assign ctl[c] = |pt[LOG_TERMS + c*CTRL_TERMS +: CTRL_TERMS];
  end

  assign grp_a = |pt[GRP_TERMS-1:0];
  assign grp_b = |pt[LOG_TERMS-1:GRP_TERMS];
  assign d_val = (grp_a | grp_b) ^ inv_i;

  assign reg_clk = clk_async_i ? ctl[CTL_CLK] : clk_i;
  assign clr_a   = ~rst_ni | ctl[CTL_CLR];
  assign pre_a   = ctl[CTL_PRE];

  mc_store u_store (
    .clk_i (reg_clk),
    .clr_i (clr_a),
    .pre_i (pre_a),
    .mode_i(mode_i),
    .d_i   (d_val),
    .a_i   (grp_a),
    .b_i   (grp_b),
    .q_o   (q)
  );

  assign val      = mode_is_reg(mode_i) ? q : d_val;
  assign pad_o    = val;
  assign pad_oe_o = ctl[CTL_OE];
  assign int_fb_o = val;
  assign pin_fb_o = ctl[CTL_OE] ? val : pad_i;
endmodule

// File: rtl/mc_chk.sv
module mc_chk
  import mc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       async_i,
  input logic       clr_i,
  input logic       pre_i,
  input logic       q_i,
  input logic       d_i,
  input logic       s_i,
  input logic       r_i,
  input logic       pad_oe_i,
  input logic       pad_o_i,
  input logic       pad_i,
  input logic       pin_fb_i
);
  assert_clr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_i);

  assert_pre_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !clr_i) |-> q_i);

  assert_d_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MC_D && !async_i && !clr_i && !pre_i)
      |=> (mode_i != MC_D || async_i || clr_i || pre_i || q_i == $past(d_i)));

  assert_sr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MC_SR && !async_i && s_i && r_i && !clr_i && !pre_i)
      |=> (mode_i != MC_SR || async_i || clr_i || pre_i || q_i == $past(q_i)));

  assert_pin_in_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_i |-> pin_fb_i == pad_i);

  assert_pin_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_i |-> pin_fb_i == pad_o_i);
endmodule

bind sop_macrocell mc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .async_i (clk_async_i),
  .clr_i   (clr_a),
  .pre_i   (pre_a),
  .q_i     (q),
  .d_i     (d_val),
  .s_i     (grp_a),
  .r_i     (grp_b),
  .pad_oe_i(pad_oe_o),
  .pad_o_i (pad_o),
  .pad_i   (pad_i),
  .pin_fb_i(pin_fb_o)
);

// File: tb/sim_sop_macrocell.sv
module sim_sop_macrocell;
  localparam int CLK_P = 10;
  localparam int NL = 8;
  localparam int NA = NL + 1;
  localparam int FW = 2 * NA;
  localparam int NT = 16;

  // {lit, inv, expected}; term0 = lit0&lit1, term4 = ~lit2
  localparam logic [9:0] VEC [6] = '{
    {8'h03, 1'b0, 1'b1},
    {8'h04, 1'b0, 1'b0},
    {8'h07, 1'b0, 1'b1},
    {8'h04, 1'b1, 1'b1},
    {8'h06, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NL-1:0] lit = '0;
  logic [NT*FW-1:0] fz = '1;
  logic [2:0] mode = 3'd0;
  logic inv = 1'b0;
  logic async_sel = 1'b0;
  logic pad_in = 1'b0;
  logic pad_o, pad_oe_o, int_fb_o, pin_fb_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sop_macrocell #(.N_LIT(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lit_i(lit), .fuse_i(fz), .mode_i(mode),
    .inv_i(inv), .clk_async_i(async_sel), .pad_i(pad_in), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .int_fb_o(int_fb_o), .pin_fb_o(pin_fb_o)
  );

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic term(int k, logic [NA-1:0] t, logic [NA-1:0] c);
    fz[k*FW +: FW] = {c, t};
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    term(8, '0, '0);            // OE always on
    @(negedge clk);
    step();
    chk("R12 reset q", int_fb_o, 1'b0);
    chk("R12 reset pad", pad_o, 1'b0);
    chk("R10 oe on", pad_oe_o, 1'b1);
    rst_ni = 1'b1;
    step();
    chk("R1 empty terms give 0", int_fb_o, 1'b0);

    // R1 R2 table in bypass
    mode = 3'd4;
    term(0, 9'b000000110, '0);
    term(4, '0, 9'b000001000);
    foreach (VEC[i]) begin
      lit = VEC[i][9:2];
      inv = VEC[i][1];
      #1;
      chk("R1/R2 bypass sop", pad_o, VEC[i][0]);
      chk("R11 int fb", int_fb_o, VEC[i][0]);
    end
    inv = 1'b0;
    mode = 3'd7;
    lit = 8'h03;
    #1 chk("R2 code7 bypass", int_fb_o, 1'b1);

    // R9 clock literal dropped in sync mode; sampled with clk low
    mode = 3'd4;
    term(0, 9'b000000011, '0);
    term(4, '1, '1);
    lit = 8'h01;
    @(negedge clk); #1;
    chk("R9 clk literal dropped", int_fb_o, 1'b1);
    async_sel = 1'b1;
    #1 chk("R9 clk literal used async", int_fb_o, 1'b0);
    async_sel = 1'b0;

    // R3 D mode
    mode = 3'd0;
    term(0, 9'b000000010, '0);
    lit = 8'h01; step();
    chk("R3 D capture 1", int_fb_o, 1'b1);
    lit = 8'h00; step();
    chk("R3 D capture 0", int_fb_o, 1'b0);
    inv = 1'b1; step();
    chk("R3 D inverted", int_fb_o, 1'b1);
    inv = 1'b0; step();
    chk("R3 D back 0", int_fb_o, 1'b0);

    // R4 T mode
    mode = 3'd1;
    lit = 8'h01; step();
    chk("R4 T toggle up", int_fb_o, 1'b1);
    step();
    chk("R4 T toggle down", int_fb_o, 1'b0);
    lit = 8'h00; step();
    chk("R4 T hold", int_fb_o, 1'b0);

    // R5 JK: J = lit0, K = lit1
    mode = 3'd2;
    term(4, 9'b000000100, '0);
    lit = 8'h01; step(); chk("R5 JK set", int_fb_o, 1'b1);
    lit = 8'h00; step(); chk("R5 JK hold", int_fb_o, 1'b1);
    lit = 8'h02; step(); chk("R5 JK reset", int_fb_o, 1'b0);
    lit = 8'h03; step(); chk("R5 JK toggle 1", int_fb_o, 1'b1);
    step();              chk("R5 JK toggle 2", int_fb_o, 1'b0);

    // R6 SR
    mode = 3'd3;
    lit = 8'h01; step(); chk("R6 SR set", int_fb_o, 1'b1);
    lit = 8'h03; step(); chk("R6 SR both hold 1", int_fb_o, 1'b1);
    lit = 8'h02; step(); chk("R6 SR reset", int_fb_o, 1'b0);
    lit = 8'h03; step(); chk("R6 SR both hold 0", int_fb_o, 1'b0);

    // R7 async preset (lit5) / clear (lit6)
    lit = 8'h00;
    term(10, 9'b001000000, '0);
    term(12, 9'b010000000, '0);
    #1;
    lit = 8'h20; #1 chk("R7 preset async", int_fb_o, 1'b1);
    lit = 8'h00; #1 chk("R7 preset released", int_fb_o, 1'b1);
    lit = 8'h60; #1 chk("R7 clear beats preset", int_fb_o, 1'b0);
    lit = 8'h00; #1 chk("R7 both released", int_fb_o, 1'b0);
    mode = 3'd0;
    lit = 8'h41; step();
    chk("R7 clear holds over clock", int_fb_o, 1'b0);
    lit = 8'h01; step();
    chk("R3 D after clear", int_fb_o, 1'b1);

    // R10 R11 output enable = lit7
    term(8, 9'b100000000, '0);
    pad_in = 1'b0; #1;
    chk("R10 oe off", pad_oe_o, 1'b0);
    chk("R10 pin fb from pad 0", pin_fb_o, 1'b0);
    chk("R11 buried int fb", int_fb_o, 1'b1);
    pad_in = 1'b1; #1;
    chk("R10 pin fb from pad 1", pin_fb_o, 1'b1);
    lit = 8'h00; pad_in = 1'b0; step();
    pad_in = 1'b1; #1;
    chk("R10 pin fb ignores q", pin_fb_o, 1'b1);
    chk("R11 pad_o still q", pad_o, 1'b0);
    lit = 8'h80; #1;
    chk("R10 oe on", pad_oe_o, 1'b1);
    chk("R10 pin fb from cell", pin_fb_o, 1'b0);

    // R8 product-term clock = lit4 rising
    lit = 8'h01; step();
    chk("R8 sync preload", int_fb_o, 1'b1);
    async_sel = 1'b1;
    term(14, 9'b000100000, '0);
    lit = 8'h00; step(); step();
    chk("R8 global edge ignored", int_fb_o, 1'b1);
    lit = 8'h10; #1 chk("R8 pt clock capture 0", int_fb_o, 1'b0);
    lit = 8'h11; #1 chk("R8 no edge no change", int_fb_o, 1'b0);
    lit = 8'h01; #1 chk("R8 falling ignored", int_fb_o, 1'b0);
    lit = 8'h11; #1 chk("R8 pt clock capture 1", int_fb_o, 1'b1);
    async_sel = 1'b0;
    lit = 8'h01;
    step();

    // R12 mid-run reset
    rst_ni = 1'b0; #1;
    chk("R12 reset clears", int_fb_o, 1'b0);
    step();
    chk("R12 reset holds over clock", int_fb_o, 1'b0);
    rst_ni = 1'b1;
    step();
    finish_run();
  end
endmodule